// File: doc/BRIEF.md
# Two-Word Composite Hamming Frame Codec

This block protects a 25-bit payload for a serial link that moves 18-bit words. On the transmit side, a payload accepted through a valid/ready handshake is split into three parts. Each part is encoded with its own single-error-correcting Hamming code: two full 15-bit codewords carry 11 payload bits each, and a 6-bit shortened codeword carries the last 3. The 36 protected bits go out as two back-to-back 18-bit words with a valid strobe.

On the receive side, the block gathers a first and a second 18-bit word. It rebuilds the three codewords and computes a syndrome for each. Where a syndrome points at a bit, that bit is corrected. The block then presents the payload with one correction flag per codeword and a flag for a shortened-code syndrome that points at the dropped position.

The transmit controller has three states. TX_IDLE goes to TX_WORD0 when a payload is offered. TX_WORD0 always goes to TX_WORD1. TX_WORD1 goes to TX_WORD0 if a new payload is offered, and otherwise back to TX_IDLE.

The receive controller has two states. RX_LOW goes to RX_HIGH when a link word arrives. RX_HIGH goes back to RX_LOW when the second word arrives. Both controllers hold their state while no word is presented.

Top module: `hframe_codec`

## Requirements
- R1: After reset, in_ready is 1, tx_valid is 0, out_valid is 0, out_fix is 0 and out_bad is 0.
- R2: A payload taken when in_valid and in_ready are both 1 at a clock edge is sent as two words. tx_valid is 1 for the two following cycles, first word 0 and then word 1. in_ready is 0 while word 0 is on the output.
- R3: Codeword A holds positions 1..15. Parity sits at positions 1, 2, 4 and 8. Payload bits [10:0] sit in ascending order at the other positions. The parity bit at position 2^j makes the XOR of all positions whose index has bit j set even. Position p appears on word 0 bit p-1.
- R4: Codeword B is built from payload bits [21:11] in the same way as A and appears on word 1 bits [14:0]. Codeword C has positions 1..6. Parity sits at positions 1, 2 and 4, and payload bits 22, 23 and 24 sit at positions 3, 5 and 6. C positions 1..3 appear on word 0 bits 15..17, and positions 4..6 on word 1 bits 15..17.
- R5: rx_valid cycles are paired as word 0, then word 1. out_valid is 1 for exactly the one cycle after the clock edge that takes word 1. For an error-free frame, out_payload equals the original payload, and out_fix and out_bad are 0.
- R6: A single flipped bit anywhere in codeword A or B is corrected. out_fix bit 0 (A) or bit 1 (B) is set for that frame.
- R7: A single flipped bit in any of the six transmitted C positions is corrected, and out_fix bit 2 is set.
- R8: A C syndrome of 7, which points at the position that is not transmitted, sets out_bad and clears out_fix bit 2. Payload bits [24:22] are then passed through exactly as received.
- R9: One flipped bit in each of A, B and C in the same frame is fully corrected, with out_fix equal to 3'b111.
- R10: Cycles with rx_valid at 0 between word 0 and word 1 are ignored. The pairing is kept, and out_valid stays 0 until word 1 arrives.
- R11: in_ready is 1 while word 1 is sent, so a payload offered then is sent straight after with no idle cycle between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload offered |
| in_ready | output | 1 | Payload can be taken |
| in_payload | input | 25 | Payload to protect |
| tx_valid | output | 1 | Link word on tx_word is valid |
| tx_word | output | 18 | Outgoing link word |
| rx_valid | input | 1 | Link word on rx_word is valid |
| rx_word | input | 18 | Incoming link word |
| out_valid | output | 1 | Decoded payload valid |
| out_payload | output | 25 | Corrected payload |
| out_fix | output | 3 | Correction applied to C, B, A (bits 2..0) |
| out_bad | output | 1 | Shortened-code syndrome pointed at the dropped position |

## Verification
The assertions check the following on every cycle:
- the transmit pair never breaks, and in_ready is low while word 0 is sent;
- the decoded-output strobe lasts one cycle and always follows a received word;
- the flags are quiet outside a valid output;
- out_bad and the C correction flag are never set together.

The correctness of the code itself can only be shown by the bench's scenarios. That covers parity placement, bit mapping onto the two words, correction of every single-bit position, the dropped-position case, and pairing across idle cycles. The bench encodes frames on its own and injects chosen and random flips.

// File: rtl/hfc_pkg.sv
package hfc_pkg;
    localparam int LW      = 18;
    localparam int M_FULL  = 4;
    localparam int N_FULL  = (1 << M_FULL) - 1;
    localparam int K_FULL  = N_FULL - M_FULL;
    localparam int M_SHORT = 3;
    localparam int N_SHORT = (1 << M_SHORT) - 2;
    localparam int K_SHORT = N_SHORT - M_SHORT;
    localparam int PAY_W   = 2 * K_FULL + K_SHORT;
    localparam int C_LO    = LW - N_FULL;

    typedef enum logic [1:0] {TX_IDLE, TX_WORD0, TX_WORD1} tx_state_t;
    typedef enum logic {RX_LOW, RX_HIGH} rx_state_t;
endpackage

// File: rtl/ham_enc.sv
module ham_enc #(
    parameter int M    = 4,
    parameter int NLEN = 15
) (
    input  logic [NLEN-M-1:0] data,
    output logic [NLEN-1:0]   cw
);
    localparam int NFULL = (1 << M) - 1;
    localparam int K     = NLEN - M;

    logic [NFULL:1] pos;
    logic           par;
    int             di;

    always_comb begin
        pos = '0;
        di  = 0;
        par = 1'b0;
        for (int p = 1; p <= NFULL; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (di < K) pos[p] = data[di];
                di = di + 1;
            end
        end
        for (int j = 0; j < M; j++) begin
            par = 1'b0;
            for (int p = 1; p <= NFULL; p++) begin
                if (((p >> j) & 1) == 1) par = par ^ pos[p];
            end
            pos[1 << j] = par;
        end
        cw = pos[NLEN:1];
    end
endmodule

// File: rtl/ham_dec.sv
module ham_dec #(
    parameter int M    = 4,
    parameter int NLEN = 15
) (
    input  logic [NLEN-1:0]   cw,
    output logic [NLEN-M-1:0] data,
    output logic              fixed_flag,
    output logic              bad_flag
);
    logic [M-1:0]   syn;
    logic [NLEN-1:0] fixd;
    int             di;

    always_comb begin
        syn = '0;
        for (int p = 1; p <= NLEN; p++) begin
            if (cw[p-1]) syn = syn ^ M'(p);
        end
    end

    always_comb begin
        fixd       = cw;
        fixed_flag = 1'b0;
        bad_flag   = 1'b0;
        if (syn != '0) begin
            if (int'(syn) <= NLEN) begin
                fixd[int'(syn) - 1] = ~cw[int'(syn) - 1];
                fixed_flag          = 1'b1;
            end else begin
                bad_flag = 1'b1;
            end
        end
    end

    always_comb begin
        data = '0;
        di   = 0;
        for (int p = 1; p <= NLEN; p++) begin
            if ((p & (p - 1)) != 0) begin
                data[di] = fixd[p-1];
                di = di + 1;
            end
        end
    end
endmodule

// File: rtl/hfrm_tx.sv
module hfrm_tx
    import hfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PAY_W-1:0] in_payload,
    output logic             tx_valid,
    output logic [LW-1:0]    tx_word
);
    tx_state_t            st, nx;
    logic [N_FULL-1:0]    cw_full [2];
    logic [N_SHORT-1:0]   cw_short;
    logic [2*LW-1:0]      frame_q;
    logic                 take;

    for (genvar g = 0; g < 2; g++) begin : g_full
        ham_enc #(.M(M_FULL), .NLEN(N_FULL)) u_enc (
            .data (in_payload[g*K_FULL +: K_FULL]),
            .cw   (cw_full[g])
        );
    end

    ham_enc #(.M(M_SHORT), .NLEN(N_SHORT)) u_enc_s (
        .data (in_payload[PAY_W-1 -: K_SHORT]),
        .cw   (cw_short)
    );

    assign take = in_valid && in_ready;

    always_comb begin
        nx = st;
        unique case (st)
            TX_IDLE:  nx = in_valid ? TX_WORD0 : TX_IDLE;
            TX_WORD0: nx = TX_WORD1;
            TX_WORD1: nx = in_valid ? TX_WORD0 : TX_IDLE;
            default:  nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) frame_q <= '0;
        else if (take)
            frame_q <= {cw_short[N_SHORT-1 -: C_LO], cw_full[1],
                        cw_short[C_LO-1:0], cw_full[0]};
    end

    always_comb begin
        in_ready = 1'b1;
        tx_valid = 1'b0;
        tx_word  = '0;
        unique case (st)
            TX_IDLE:  ;
            TX_WORD0: begin
                in_ready = 1'b0;
                tx_valid = 1'b1;
                tx_word  = frame_q[LW-1:0];
            end
            TX_WORD1: begin
                tx_valid = 1'b1;
                tx_word  = frame_q[2*LW-1:LW];
            end
            default:  ;
        endcase
    end

    assert_pair_unbroken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !in_ready) |=> tx_valid);
    assert_first_word_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> !in_ready);
    assert_second_word_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !in_ready) |=> in_ready);
endmodule

// File: rtl/hfrm_rx.sv
module hfrm_rx
    import hfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [LW-1:0]    rx_word,
    output logic             out_valid,
    output logic [PAY_W-1:0] out_payload,
    output logic [2:0]       out_fix,
    output logic             out_bad
);
    rx_state_t            st, nx;
    logic [LW-1:0]        low_q;
    logic [N_FULL-1:0]    cw_full [2];
    logic [N_SHORT-1:0]   cw_short;
    logic [K_FULL-1:0]    d_full [2];
    logic [K_SHORT-1:0]   d_short;
    logic [1:0]           fx_full, bad_full;
    logic                 fx_short, bad_short;
    logic                 done;

    assign cw_full[0] = low_q[N_FULL-1:0];
    assign cw_full[1] = rx_word[N_FULL-1:0];
    assign cw_short   = {rx_word[LW-1:N_FULL], low_q[LW-1:N_FULL]};

    for (genvar g = 0; g < 2; g++) begin : g_full
        ham_dec #(.M(M_FULL), .NLEN(N_FULL)) u_dec (
            .cw         (cw_full[g]),
            .data       (d_full[g]),
            .fixed_flag (fx_full[g]),
            .bad_flag   (bad_full[g])
        );
    end

    ham_dec #(.M(M_SHORT), .NLEN(N_SHORT)) u_dec_s (
        .cw         (cw_short),
        .data       (d_short),
        .fixed_flag (fx_short),
        .bad_flag   (bad_short)
    );

    assign done = (st == RX_HIGH) && rx_valid;

    always_comb begin
        nx = st;
        unique case (st)
            RX_LOW:  nx = rx_valid ? RX_HIGH : RX_LOW;
            RX_HIGH: nx = rx_valid ? RX_LOW  : RX_HIGH;
            default: nx = RX_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RX_LOW;
        else        st <= nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q       <= '0;
            out_valid   <= 1'b0;
            out_payload <= '0;
            out_fix     <= '0;
            out_bad     <= 1'b0;
        end else begin
            if ((st == RX_LOW) && rx_valid) low_q <= rx_word;
            out_valid <= done;
            if (done) begin
                out_payload <= {d_short, d_full[1], d_full[0]};
                out_fix     <= {fx_short, fx_full[1], fx_full[0]};
                out_bad     <= bad_short | (|bad_full);
            end else begin
                out_fix <= '0;
                out_bad <= 1'b0;
            end
        end
    end

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    assert_follows_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(rx_valid));
    assert_quiet_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_fix == 3'b000 && !out_bad));
    assert_bad_not_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_bad |-> !out_fix[2]);
endmodule

// File: rtl/hframe_codec.sv
module hframe_codec
    import hfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PAY_W-1:0] in_payload,
    output logic             tx_valid,
    output logic [LW-1:0]    tx_word,
    input  logic             rx_valid,
    input  logic [LW-1:0]    rx_word,
    output logic             out_valid,
    output logic [PAY_W-1:0] out_payload,
    output logic [2:0]       out_fix,
    output logic             out_bad
);
    hfrm_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_payload (in_payload),
        .tx_valid   (tx_valid),
        .tx_word    (tx_word)
    );

    hfrm_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_word     (rx_word),
        .out_valid   (out_valid),
        .out_payload (out_payload),
        .out_fix     (out_fix),
        .out_bad     (out_bad)
    );
endmodule

// File: tb/tb_hframe_codec.sv
module tb_hframe_codec;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [24:0] in_payload = '0;
    logic        tx_valid;
    logic [17:0] tx_word;
    logic        rx_valid = 1'b0;
    logic [17:0] rx_word = '0;
    logic        out_valid;
    logic [24:0] out_payload;
    logic [2:0]  out_fix;
    logic        out_bad;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hframe_codec dut (.*);

    function automatic logic [15:1] benc(input int n, input logic [10:0] d);
        logic [15:1] v;
        logic x;
        int k;
        v = '0;
        k = 0;
        for (int p = 1; p <= n; p++) begin
            if (p != 1 && p != 2 && p != 4 && p != 8) begin
                v[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < 4; b++) begin
            if ((1 << b) <= n) begin
                x = 1'b0;
                for (int p = 1; p <= n; p++) if ((p & (1 << b)) != 0) x ^= v[p];
                v[1 << b] = x;
            end
        end
        return v;
    endfunction

    function automatic logic [35:0] bframe(input logic [24:0] pl);
        logic [15:1] a, b, c;
        a = benc(15, pl[10:0]);
        b = benc(15, pl[21:11]);
        c = benc(6, {8'b0, pl[24:22]});
        return {c[6:4], b[15:1], c[3:1], a[15:1]};
    endfunction

    function automatic int fbit(input int cwi, input int p);
        if (cwi == 0) return p - 1;
        if (cwi == 1) return 17 + p;
        if (p <= 3) return 14 + p;
        return 29 + p;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_tx(input logic [24:0] pl);
        logic [35:0] f;
        f = bframe(pl);
        @(negedge clk);
        in_valid = 1'b1;
        in_payload = pl;
        chk(in_ready == 1'b1, "R2 ready before send", 36'(in_ready), 36'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(tx_valid && !in_ready, "R2 word0 strobe/ready", {34'd0, tx_valid, in_ready}, 36'd2);
        chk(tx_word == f[17:0], "R3 word0 content", 36'(tx_word), 36'(f[17:0]));
        @(negedge clk);
        chk(tx_valid && tx_word == f[35:18], "R4 word1 content", 36'(tx_word), 36'(f[35:18]));
        chk(in_ready == 1'b1, "R11 ready during word1", 36'(in_ready), 36'd1);
        @(negedge clk);
        chk(!tx_valid, "R2 two words only", 36'(tx_valid), 36'd0);
    endtask

    task automatic send_rx(input logic [35:0] f, input int gap, input logic [24:0] exp_pl,
                           input logic [2:0] exp_fix, input logic exp_bad, input string req);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_word = f[17:0];
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            rx_valid = 1'b0;
            rx_word = $urandom;
            if (i > 0) chk(!out_valid, "R10 no output mid-frame", 36'(out_valid), 36'd0);
        end
        @(negedge clk);
        if (gap > 0) chk(!out_valid, "R10 no output mid-frame", 36'(out_valid), 36'd0);
        rx_valid = 1'b1;
        rx_word = f[35:18];
        @(negedge clk);
        rx_valid = 1'b0;
        chk(out_valid && out_payload == exp_pl, {req, " payload"}, 36'(out_payload), 36'(exp_pl));
        chk(out_fix == exp_fix && out_bad == exp_bad, {req, " flags"},
            36'({out_bad, out_fix}), 36'({exp_bad, exp_fix}));
        @(negedge clk);
        chk(!out_valid, "R5 one-cycle strobe", 36'(out_valid), 36'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [24:0] pl, p2;
        logic [35:0] f, f2;
        int mode, pa, pb, pc;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready && !tx_valid && !out_valid && out_fix == 0 && !out_bad, "R1 reset state",
            {31'd0, in_ready, tx_valid, out_valid, out_bad, |out_fix}, 36'h10);
        rst_n = 1'b1;

        send_tx(25'h0000000);
        send_tx(25'h1FFFFFF);
        send_tx(25'h0000001);
        send_tx(25'h1C00000);
        for (int i = 0; i < 20; i++) send_tx(25'($urandom));

        // R11 back-to-back frames
        pl = 25'h0AAAAAA; p2 = 25'h1555555;
        f = bframe(pl); f2 = bframe(p2);
        @(negedge clk);
        in_valid = 1'b1; in_payload = pl;
        @(negedge clk);
        in_payload = p2;
        chk(tx_word == f[17:0] && !in_ready, "R11 frame1 word0", 36'(tx_word), 36'(f[17:0]));
        @(negedge clk);
        chk(tx_word == f[35:18] && in_ready, "R11 frame1 word1", 36'(tx_word), 36'(f[35:18]));
        @(negedge clk);
        in_valid = 1'b0;
        chk(tx_valid && tx_word == f2[17:0], "R11 frame2 word0 no gap", 36'(tx_word), 36'(f2[17:0]));
        @(negedge clk);
        chk(tx_valid && tx_word == f2[35:18], "R11 frame2 word1", 36'(tx_word), 36'(f2[35:18]));
        @(negedge clk);

        send_rx(bframe(25'h0123456), 0, 25'h0123456, 3'b000, 1'b0, "R5 clean");
        send_rx(bframe(25'h1FFFFFF), 3, 25'h1FFFFFF, 3'b000, 1'b0, "R10 gapped clean");

        for (int p = 1; p <= 15; p++) begin
            f = bframe(25'h0F0F0F0); f[fbit(0, p)] ^= 1'b1;
            send_rx(f, 0, 25'h0F0F0F0, 3'b001, 1'b0, "R6 A flip");
            f = bframe(25'h1234567); f[fbit(1, p)] ^= 1'b1;
            send_rx(f, 1, 25'h1234567, 3'b010, 1'b0, "R6 B flip");
        end
        for (int p = 1; p <= 6; p++) begin
            f = bframe(25'h1ABCDEF); f[fbit(2, p)] ^= 1'b1;
            send_rx(f, 0, 25'h1ABCDEF, 3'b100, 1'b0, "R7 C flip");
        end

        // R8 syndrome 7 in C: pairs (1,6), (2,5), (3,4) pass data through
        pl = 25'h0000000;
        f = bframe(pl); f[fbit(2, 1)] ^= 1'b1; f[fbit(2, 6)] ^= 1'b1;
        send_rx(f, 0, pl ^ 25'h1000000, 3'b000, 1'b1, "R8 syn7 1+6");
        f = bframe(pl); f[fbit(2, 2)] ^= 1'b1; f[fbit(2, 5)] ^= 1'b1;
        send_rx(f, 0, pl ^ 25'h0800000, 3'b000, 1'b1, "R8 syn7 2+5");
        f = bframe(pl); f[fbit(2, 3)] ^= 1'b1; f[fbit(2, 4)] ^= 1'b1;
        send_rx(f, 2, pl ^ 25'h0400000, 3'b000, 1'b1, "R8 syn7 3+4");

        for (int i = 0; i < 150; i++) begin
            pl = 25'($urandom);
            f = bframe(pl);
            mode = $urandom_range(0, 4);
            pa = $urandom_range(1, 15); pb = $urandom_range(1, 15); pc = $urandom_range(1, 6);
            case (mode)
                0: send_rx(f, $urandom_range(0, 2), pl, 3'b000, 1'b0, "R5 random clean");
                1: begin f[fbit(0, pa)] ^= 1'b1; send_rx(f, 0, pl, 3'b001, 1'b0, "R6 random A"); end
                2: begin f[fbit(1, pb)] ^= 1'b1; send_rx(f, 0, pl, 3'b010, 1'b0, "R6 random B"); end
                3: begin f[fbit(2, pc)] ^= 1'b1; send_rx(f, 1, pl, 3'b100, 1'b0, "R7 random C"); end
                default: begin
                    f[fbit(0, pa)] ^= 1'b1; f[fbit(1, pb)] ^= 1'b1; f[fbit(2, pc)] ^= 1'b1;
                    send_rx(f, 0, pl, 3'b111, 1'b0, "R9 triple");
                end
            endcase
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule